// File: doc/BRIEF.md
# NAND Bad-Block Scan Controller

This block runs on the host side of a NAND array. It finds blocks that were marked unusable at manufacture, and it must run before the array is put into service. A one-cycle start pulse launches a scan. The scan visits every block in ascending order. For each block it issues one read to a simple request/response port, which stands in for the NAND controller. The read targets page 0 of that block at a fixed marker column. A returned byte equal to the erased value (FFh) means the block is usable. Any other byte flags the block as bad. Each verdict is written into a one-bit-per-block map held in inferable block RAM.

When the scan finishes, the controller pulses a done strobe and presents four results:
- the number of bad blocks found;
- a count error, raised when fewer usable blocks remain than the array guarantees;
- a separate error raised when block 0 (which is guaranteed good) reads as bad;
- the completed map.

Higher layers send erase requests through a gate that consults the map. The gate answers every request one cycle later with either a grant or a reject. A block flagged bad is never granted. Until a scan has completed, and for as long as one is running, every request is rejected.

Top module: `nand_badblock_scan`

## Requirements
- R1: After reset, scan_busy, scan_done, rd_req, bad_count, count_err, blk0_err, er_grant and er_reject are all 0.
- R2: A scan_start pulse while idle raises scan_busy and rd_req at the next clock edge. Each rd_req lasts one cycle. rd_col always carries the marker column (517 by default). The request for block b+1 is issued at the clock edge that accepts the response for block b.
- R3: During a request, rd_row holds the block index in its upper BLK_W bits and zero in its low PG_W page bits, so each block is read at its first page.
- R4: A response byte equal to FFh marks the block good. Any other value marks it bad in the map. The map is rewritten by every scan.
- R5: bad_count is cleared when a scan starts and increases by one for each bad verdict.
- R6: scan_done pulses for exactly one cycle, at the same edge where scan_busy falls, right after the response for the last block is accepted.
- R7: At the end of a scan, count_err goes to 1 if bad_count exceeds NUM_BLOCKS − MIN_GOOD, and to 0 otherwise. It is cleared at the next start.
- R8: blk0_err is 1 after block 0 returns a byte other than FFh, and is cleared at the next start.
- R9: Each er_req cycle is answered in the next cycle with exactly one of er_grant or er_reject. A block flagged bad is always rejected.
- R10: Erase requests are rejected while a scan is running and before the first scan has completed.
- R11: scan_start while a scan is running has no effect.
- R12: rd_valid is ignored while idle and in the cycle in which rd_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Start pulse |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle end-of-scan strobe |
| bad_count | output | CNT_W | Bad blocks found in the current or last scan |
| count_err | output | 1 | Too few good blocks |
| blk0_err | output | 1 | Block 0 marker not erased |
| rd_req | output | 1 | Read request strobe |
| rd_row | output | ROW_W | Row address (block, page) |
| rd_col | output | COL_W | Column address of the marker byte |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Marker byte returned |
| er_req | input | 1 | Erase request |
| er_blk | input | BLK_W | Block named in the erase request |
| er_grant | output | 1 | Erase allowed |
| er_reject | output | 1 | Erase refused |

## Verification
The bench builds the block with 64 blocks and at least 60 good, which sets the count-error threshold at 4 bad blocks. Both sides of that threshold are reachable with short patterns: 3, 4 and 8 bad blocks. The full scan also stays a few hundred cycles long, so several scans fit in one run, with marker patterns that hit block 0 and the last block. Read latency is varied from the one-cycle minimum up to four cycles, and also per block. This exercises the case where a response arrives while the following request is being issued.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_WAIT = 1'b1
  } scan_st_e;
endpackage

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic          wd,
  input  logic [AW-1:0] ra,
  output logic          rq
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/bbs_scan_seq.sv
module bbs_scan_seq
  import bbs_pkg::*;
#(
  parameter int          NUM_BLOCKS      = 1024,
  parameter int          PAGES_PER_BLOCK = 32,
  parameter int          DATA_W          = 8,
  parameter int          CNT_W           = 11,
  parameter int          MIN_GOOD        = 1004,
  parameter logic [7:0]  ERASED_VAL      = 8'hFF,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              map_ok_o,
  output logic [CNT_W-1:0]  bad_cnt_o,
  output logic              cnt_err_o,
  output logic              blk0_err_o,
  output logic              map_we_o,
  output logic [BLK_W-1:0]  map_wa_o,
  output logic              map_wd_o
);
  localparam int BAD_LIMIT = NUM_BLOCKS - MIN_GOOD;

  scan_st_e           st_q;
  logic [BLK_W-1:0]   blk_q;
  logic               req_q, done_q, ok_q, cerr_q, b0_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               take, bad, last;
  logic [CNT_W-1:0]   cnt_nxt;

  assign take    = (st_q == SCAN_WAIT) && rd_valid_i && !req_q;
  assign bad     = rd_data_i != DATA_W'(ERASED_VAL);
  assign last    = blk_q == BLK_W'(NUM_BLOCKS - 1);
  assign cnt_nxt = cnt_q + CNT_W'(bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SCAN_IDLE;
      blk_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      cerr_q <= 1'b0;
      b0_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      case (st_q)
        SCAN_IDLE: begin
          if (start_i) begin
            st_q   <= SCAN_WAIT;
            blk_q  <= '0;
            req_q  <= 1'b1;
            cnt_q  <= '0;
            ok_q   <= 1'b0;
            cerr_q <= 1'b0;
            b0_q   <= 1'b0;
          end
        end
        SCAN_WAIT: begin
          if (take) begin
            cnt_q <= cnt_nxt;
            if (blk_q == '0) b0_q <= bad;
            if (last) begin
              st_q   <= SCAN_IDLE;
              done_q <= 1'b1;
              ok_q   <= 1'b1;
              cerr_q <= int'(cnt_nxt) > BAD_LIMIT;
            end else begin
              blk_q <= blk_q + 1'b1;
              req_q <= 1'b1;
            end
          end
        end
        default: st_q <= SCAN_IDLE;
      endcase
    end
  end

  assign rd_req_o   = req_q;
  assign rd_row_o   = {blk_q, {PG_W{1'b0}}};
  assign busy_o     = st_q == SCAN_WAIT;
  assign done_o     = done_q;
  assign map_ok_o   = ok_q;
  assign bad_cnt_o  = cnt_q;
  assign cnt_err_o  = cerr_q;
  assign blk0_err_o = b0_q;
  assign map_we_o   = take;
  assign map_wa_o   = blk_q;
  assign map_wd_o   = bad;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> st_q == SCAN_IDLE);
  // R2
  req_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> st_q == SCAN_WAIT);
  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
  // R5
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SCAN_WAIT && $past(st_q) == SCAN_WAIT) |-> cnt_q >= $past(cnt_q));
  // R11
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SCAN_WAIT && start_i && !(take && last)) |=> st_q == SCAN_WAIT);
  // R7
  cerr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cerr_q |-> st_q == SCAN_IDLE);
endmodule

// File: rtl/bbs_erase_gate.sv
module bbs_erase_gate (
  input  logic clk,
  input  logic rst,
  input  logic er_req_i,
  input  logic busy_i,
  input  logic map_ok_i,
  input  logic bad_bit_i,
  output logic grant_o,
  output logic reject_o
);
  logic pend_q, allow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      allow_q <= 1'b0;
    end else begin
      pend_q  <= er_req_i;
      allow_q <= map_ok_i && !busy_i;
    end
  end

  assign grant_o  = pend_q && allow_q && !bad_bit_i;
  assign reject_o = pend_q && !(allow_q && !bad_bit_i);

  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    er_req_i |=> (grant_o ^ reject_o));
  // R9
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && reject_o));
  // R10
  busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (er_req_i && busy_i) |=> reject_o);
  // R10
  unmapped_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (er_req_i && !map_ok_i) |=> reject_o);
endmodule

// File: rtl/nand_badblock_scan.sv
module nand_badblock_scan #(
  parameter int         NUM_BLOCKS      = 1024,
  parameter int         PAGES_PER_BLOCK = 32,
  parameter int         COL_W           = 10,
  parameter int         MARKER_COL      = 517,
  parameter int         DATA_W          = 8,
  parameter int         CNT_W           = 11,
  parameter int         MIN_GOOD        = 1004,
  parameter logic [7:0] ERASED_VAL      = 8'hFF,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_start,
  output logic              scan_busy,
  output logic              scan_done,
  output logic [CNT_W-1:0]  bad_count,
  output logic              count_err,
  output logic              blk0_err,
  output logic              rd_req,
  output logic [ROW_W-1:0]  rd_row,
  output logic [COL_W-1:0]  rd_col,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              er_req,
  input  logic [BLK_W-1:0]  er_blk,
  output logic              er_grant,
  output logic              er_reject
);
  logic             map_ok, map_we, map_wd, map_rq;
  logic [BLK_W-1:0] map_wa;

  assign rd_col = COL_W'(MARKER_COL);

  bbs_scan_seq #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_GOOD(MIN_GOOD),
    .ERASED_VAL(ERASED_VAL)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(scan_start),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .rd_req_o(rd_req), .rd_row_o(rd_row),
    .busy_o(scan_busy), .done_o(scan_done), .map_ok_o(map_ok),
    .bad_cnt_o(bad_count), .cnt_err_o(count_err), .blk0_err_o(blk0_err),
    .map_we_o(map_we), .map_wa_o(map_wa), .map_wd_o(map_wd)
  );

  bbs_bitmap #(.DEPTH(NUM_BLOCKS)) u_map (
    .clk(clk), .we(map_we), .wa(map_wa), .wd(map_wd),
    .ra(er_blk), .rq(map_rq)
  );

  bbs_erase_gate u_gate (
    .clk(clk), .rst(rst), .er_req_i(er_req), .busy_i(scan_busy),
    .map_ok_i(map_ok), .bad_bit_i(map_rq),
    .grant_o(er_grant), .reject_o(er_reject)
  );
endmodule

// File: tb/nand_badblock_scan_tb.sv
module nand_badblock_scan_tb;
  localparam int NB = 64, MINOK = 60, PG_W = 5, COL = 517;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, er_req = 1'b0;
  logic stray_v = 1'b0, resp_v = 1'b0;
  logic [7:0] stray_d = 8'h00, resp_d = 8'h00;
  logic [5:0] er_blk = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic busy, done, cerr, b0err, rd_req, grant, reject;
  logic [10:0] cnt;
  logic [10:0] row;
  logic [9:0] col;

  assign rd_valid = resp_v | stray_v;
  assign rd_data  = resp_v ? resp_d : stray_d;

  nand_badblock_scan #(.NUM_BLOCKS(NB), .MIN_GOOD(MINOK)) u_dut (
    .clk(clk), .rst(rst), .scan_start(start), .scan_busy(busy),
    .scan_done(done), .bad_count(cnt), .count_err(cerr), .blk0_err(b0err),
    .rd_req(rd_req), .rd_row(row), .rd_col(col), .rd_valid(rd_valid),
    .rd_data(rd_data), .er_req(er_req), .er_blk(er_blk),
    .er_grant(grant), .er_reject(reject)
  );

  always #2.5ns clk = ~clk;

  int vecs = 0, fails = 0, scan_id = 0, rcnt = 0, rblk = 0, cyc = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mark(input int s, input int b);
    case (s)
      0: begin
        if (b == 3) return 8'h00;
        if (b == 17) return 8'h7F;
        if (b == 40) return 8'hFE;
      end
      1: begin
        if (b == 0) return 8'h3C;
        if (b % 9 == 4) return 8'((b * 3) & 8'hFE);
      end
      2: if (b == 63) return 8'hFE;
      default: if (b == 1 || b == 2 || b == 62 || b == 63) return 8'h10;
    endcase
    return 8'hFF;
  endfunction

  function automatic int latency(input int s, input int b);
    case (s)
      0: return 1 + b % 3;
      1: return 1;
      2: return 4;
      default: return 2;
    endcase
  endfunction

  // responder
  always @(negedge clk) begin
    resp_v = 1'b0;
    if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin
        resp_v = 1'b1;
        resp_d = mark(scan_id, rblk);
      end
    end
    if (rd_req) begin
      rblk = int'(row) >> PG_W;
      rcnt = latency(scan_id, rblk);
    end
  end

  // behavioural reference
  bit m_busy, m_done, m_req, m_ok, m_cerr, m_b0, m_gr, m_rj;
  int m_blk, m_cnt;
  bit m_map [NB];

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_req <= 0; m_ok <= 0; m_cerr <= 0;
      m_b0 <= 0; m_gr <= 0; m_rj <= 0; m_blk <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0; m_req <= 0; m_gr <= 0; m_rj <= 0;
      if (er_req) begin
        if (m_ok && !m_busy && !m_map[er_blk]) m_gr <= 1; else m_rj <= 1;
      end
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1; m_blk <= 0; m_cnt <= 0; m_req <= 1;
          m_ok <= 0; m_cerr <= 0; m_b0 <= 0;
        end
      end else if (rd_valid && !m_req) begin
        bit bad;
        int nc;
        bad = rd_data != 8'hFF;
        m_map[m_blk] = bad;
        nc = m_cnt + int'(bad);
        m_cnt <= nc;
        if (m_blk == 0) m_b0 <= bad;
        if (m_blk == NB - 1) begin
          m_busy <= 0; m_done <= 1; m_ok <= 1; m_cerr <= nc > NB - MINOK;
        end else begin
          m_blk <= m_blk + 1; m_req <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(busy == m_busy, "R2 busy", int'(busy), int'(m_busy));
      chk(rd_req == m_req, "R2 rd_req", int'(rd_req), int'(m_req));
      if (m_req) begin
        chk(int'(row) == (m_blk << PG_W), "R3 row", int'(row), m_blk << PG_W);
        chk(int'(col) == COL, "R2 col", int'(col), COL);
      end
      chk(done == m_done, "R6 done", int'(done), int'(m_done));
      chk(int'(cnt) == m_cnt, "R5 count", int'(cnt), m_cnt);
      chk(cerr == m_cerr, "R7 count_err", int'(cerr), int'(m_cerr));
      chk(b0err == m_b0, "R8 blk0_err", int'(b0err), int'(m_b0));
      chk(grant == m_gr, "R9 grant", int'(grant), int'(m_gr));
      chk(reject == m_rj, "R9 reject", int'(reject), int'(m_rj));
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, "R6 scan end", t, 0);
  endtask

  task automatic probe(input int b, input bit exp_grant, input string tag);
    @(negedge clk); er_blk = 6'(b); er_req = 1'b1;
    @(negedge clk); er_req = 1'b0;
    chk(grant == exp_grant && reject == !exp_grant, tag, int'(grant), int'(exp_grant));
  endtask

  task automatic run_scan(input int s, input int exp_cnt, input bit exp_cerr, input bit exp_b0);
    scan_id = s;
    pulse_start();
    wait_done();
    chk(int'(cnt) == exp_cnt, "R5 final count", int'(cnt), exp_cnt);
    chk(cerr == exp_cerr, "R7 final count_err", int'(cerr), int'(exp_cerr));
    chk(b0err == exp_b0, "R8 final blk0_err", int'(b0err), int'(exp_b0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !rd_req && cnt == 0 && !cerr && !b0err && !grant && !reject,
        "R1 reset state", int'(busy | done | rd_req | grant | reject), 0);
    rst = 1'b0;
    cmp_en = 1'b1;

    probe(5, 1'b0, "R10 before first scan");

    @(negedge clk); stray_v = 1'b1; stray_d = 8'h00;
    @(negedge clk); stray_v = 1'b0;
    @(negedge clk);
    chk(cnt == 0 && !rd_req && !busy, "R12 stray response", int'(cnt), 0);

    // scan 0: three bad blocks, mixed latency, restart attempt mid-scan
    scan_id = 0;
    pulse_start();
    repeat (6) @(negedge clk);
    er_blk = 6'd4; er_req = 1'b1;
    @(negedge clk); er_req = 1'b0;
    chk(reject && !grant, "R10 during scan", int'(reject), 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(cnt == 3, "R11 restart ignored", int'(cnt), 3);
    chk(!cerr && !b0err, "R7 under threshold", int'(cerr), 0);
    @(negedge clk);
    chk(!busy, "R11 no relaunch", int'(busy), 0);
    probe(3, 1'b0, "R4 byte 00 bad");
    probe(17, 1'b0, "R4 byte 7F bad");
    probe(40, 1'b0, "R4 byte FE bad");
    probe(4, 1'b1, "R4 good block granted");
    probe(0, 1'b1, "R9 block 0 granted");

    run_scan(1, 8, 1'b1, 1'b1);
    probe(0, 1'b0, "R9 bad block 0 rejected");

    run_scan(2, 1, 1'b0, 1'b0);
    probe(63, 1'b0, "R4 last block bad");
    probe(3, 1'b1, "R4 map rewritten");

    run_scan(3, 4, 1'b0, 1'b0);
    probe(62, 1'b0, "R9 boundary scan reject");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule